// File: doc/BRIEF.md
# Interlaced Field Vertical Sequencer

This block tracks the vertical position of an interlaced video stream and turns it into the vertical control a small delta-pixel panel needs. A one-cycle strobe at the start of every line advances a line counter, and the rising edge of vertical sync restarts it at line 1. Field parity comes from where that sync edge falls inside the current line: an edge in the middle half of the line marks the half-line field (even), and an edge near a line boundary marks the odd field.

For each line the block flags whether the line belongs to the displayed window and drives a one-line-wide vertical start pulse three lines before the first displayed line. The pulse leaves on one of two start pins chosen by scan direction, and the other pin is released. With the 625-line standard selected, the field holds more lines than the panel has rows. The block therefore marks two lines out of every fourteen as skipped, at offsets that depend on field parity. Standard select and direction select are sampled only at the sync edge, so they cannot change in the middle of a field. If sync goes missing, the counter stops at its limit and raises an error flag until the next sync.

Top module: `vfield_seq`

## Requirements
- R1: After reset, start_a_oe is 1. start_a_out, start_b_out, start_b_oe, line_valid, line_skip, field_even and line_err are all 0.
- R2: A rising vsync edge sets the line number to 1, and each later line_stb adds one. The start pulse is high for exactly the line whose number plus 3 equals the first displayed line (line 19 for 525-line, line 25 for 625-line).
- R3: With the latched direction 0, start_a_oe=1, start_b_oe=0, and the pulse appears on start_a_out. With the latched direction 1, start_b_oe=1, start_a_oe=0, and the pulse appears on start_b_out. A released pin's data output is always 0.
- R4: With pal_sel=0 latched, line_valid is 1 exactly for lines 22 to 256 inclusive, and line_skip stays 0.
- R5: With pal_sel=1 latched, the window covers lines 28 to 299. For row = line - 28, rows with row mod 14 equal to 6 or 12 (odd field), or to 3 or 10 (even field), give line_skip=1 and line_valid=0. Every other row in the window gives line_valid=1.
- R6: field_even becomes 1 when the vsync edge arrives with the in-line clock position in [LINE_CLKS/4, 3*LINE_CLKS/4), and 0 otherwise. It holds that value until the next vsync edge.
- R7: Changes on pal_sel or dir_up between sync edges have no effect on any output until the next vsync edge.
- R8: The line number saturates at 320, and line_err is 1 while it sits there. While line_err is 1, line_valid, line_skip and the start pulse are 0. The next vsync edge clears line_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe at each line start |
| vsync | input | 1 | Vertical sync, rising edge is the field reference |
| pal_sel | input | 1 | 1 selects the 625-line standard, 0 the 525-line standard |
| dir_up | input | 1 | 1 scans bottom to top (pin B), 0 scans top to bottom (pin A) |
| start_a_out | output | 1 | Start pulse data for pin A |
| start_a_oe | output | 1 | Drive enable for pin A |
| start_b_out | output | 1 | Start pulse data for pin B |
| start_b_oe | output | 1 | Drive enable for pin B |
| line_valid | output | 1 | Current line is shown on the panel |
| line_skip | output | 1 | Current line is inside the window but dropped |
| field_even | output | 1 | Parity of the current field |
| line_err | output | 1 | Line count saturated without a sync |

## Verification
Some properties are checked by assertions on every cycle. Exactly one start pin is enabled at any time. The latched configuration moves only on a sync edge. The line count never passes its limit, and the error flag matches saturation. A valid line and a skipped line are never flagged together, and no skip occurs in 525-line mode. The start pulse can rise only after a strobe or a sync edge. Other behaviour is shown only by the bench scenarios, which sweep every standard, direction and parity over whole fields and compare every line against window and skip arithmetic computed in the bench. These cover the exact window bounds, the skip offsets, where the start pulse lands, the ignoring of mid-field configuration changes, and recovery from a missing sync.

// File: rtl/vfield_pkg.sv
package vfield_pkg;

  typedef struct packed {
    logic pal;
    logic up;
    logic even;
  } field_cfg_t;

  function automatic logic in_span(int unsigned n, int unsigned lo, int unsigned hi);
    return (n >= lo) && (n <= hi);
  endfunction

  function automatic logic skip_hit(int unsigned row, int unsigned period,
                                    int unsigned off_a, int unsigned off_b);
    int unsigned ph;
    ph = row % period;
    return (ph == off_a) || (ph == off_b);
  endfunction

endpackage

// File: rtl/vfield_sync_capture.sv
module vfield_sync_capture
  import vfield_pkg::*;
#(
  parameter int LINE_CLKS = 64,
  localparam int POS_W = $clog2(LINE_CLKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       vsync,
  input  logic       pal_sel,
  input  logic       dir_up,
  output logic       vs_edge,
  output field_cfg_t cfg
);

  localparam logic [POS_W-1:0] POS_Q1  = POS_W'(LINE_CLKS / 4);
  localparam logic [POS_W-1:0] POS_Q3  = POS_W'((3 * LINE_CLKS) / 4);
  localparam logic [POS_W-1:0] POS_TOP = POS_W'(LINE_CLKS);

  logic             vs_d;
  logic [POS_W-1:0] pos;
  logic             mid_line;

  assign vs_edge  = vsync & ~vs_d;
  assign mid_line = (pos >= POS_Q1) && (pos < POS_Q3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d <= 1'b0;
      pos  <= '0;
      cfg  <= '0;
    end else begin
      vs_d <= vsync;
      if (line_stb)
        pos <= '0;
      else if (pos != POS_TOP)
        pos <= pos + 1'b1;
      if (vs_edge)
        cfg <= '{pal: pal_sel, up: dir_up, even: mid_line};
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(cfg)); // R7

endmodule

// File: rtl/vfield_line_counter.sv
module vfield_line_counter #(
  parameter int MAX_LINES = 320,
  localparam int CNT_W = $clog2(MAX_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             vs_edge,
  output logic [CNT_W-1:0] cnt,
  output logic             err
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LINES);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(MAX_LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else if (vs_edge) begin
      cnt <= CNT_W'(1);
      err <= 1'b0;
    end else if (line_stb) begin
      if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (cnt >= CNT_PRE)
        err <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX); // R8
  AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cnt == CNT_MAX)); // R8
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> (cnt == CNT_W'(1)) && !err); // R2

endmodule

// File: rtl/vfield_window.sv
module vfield_window
  import vfield_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int NTSC_FIRST  = 22,
  parameter int NTSC_LAST   = 256,
  parameter int PAL_FIRST   = 28,
  parameter int PAL_LAST    = 299,
  parameter int TSV         = 3,
  parameter int SKIP_PERIOD = 14,
  parameter int ODD_SKIP_A  = 6,
  parameter int ODD_SKIP_B  = 12,
  parameter int EVEN_SKIP_A = 3,
  parameter int EVEN_SKIP_B = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             err,
  input  field_cfg_t       cfg,
  output logic             valid,
  output logic             skip,
  output logic             pulse
);

  int unsigned n, first, last, row;
  logic        in_win, hit;

  always_comb begin
    n      = 32'(cnt);
    first  = cfg.pal ? PAL_FIRST : NTSC_FIRST;
    last   = cfg.pal ? PAL_LAST  : NTSC_LAST;
    row    = n - first;
    in_win = !err && in_span(n, first, last);
    hit    = cfg.even ? skip_hit(row, SKIP_PERIOD, EVEN_SKIP_A, EVEN_SKIP_B)
                      : skip_hit(row, SKIP_PERIOD, ODD_SKIP_A, ODD_SKIP_B);
    skip   = in_win && cfg.pal && hit;
    valid  = in_win && !skip;
    pulse  = !err && ((n + TSV) == first);
  end

  AST_VALID_SKIP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && skip)); // R5
  AST_NTSC_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.pal |-> !skip); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid && !skip && !pulse); // R8

endmodule

// File: rtl/vfield_seq.sv
module vfield_seq
  import vfield_pkg::*;
#(
  parameter int LINE_CLKS   = 64,
  parameter int MAX_LINES   = 320,
  parameter int NTSC_FIRST  = 22,
  parameter int NTSC_LAST   = 256,
  parameter int PAL_FIRST   = 28,
  parameter int PAL_LAST    = 299,
  parameter int TSV         = 3,
  parameter int SKIP_PERIOD = 14,
  parameter int ODD_SKIP_A  = 6,
  parameter int ODD_SKIP_B  = 12,
  parameter int EVEN_SKIP_A = 3,
  parameter int EVEN_SKIP_B = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic vsync,
  input  logic pal_sel,
  input  logic dir_up,
  output logic start_a_out,
  output logic start_a_oe,
  output logic start_b_out,
  output logic start_b_oe,
  output logic line_valid,
  output logic line_skip,
  output logic field_even,
  output logic line_err
);

  localparam int CNT_W = $clog2(MAX_LINES + 1);

  logic             vs_edge;
  field_cfg_t       cfg;
  logic [CNT_W-1:0] line_no;
  logic             start_pulse;

  vfield_sync_capture #(.LINE_CLKS(LINE_CLKS)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync(vsync),
    .pal_sel(pal_sel), .dir_up(dir_up), .vs_edge(vs_edge), .cfg(cfg)
  );

  vfield_line_counter #(.MAX_LINES(MAX_LINES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vs_edge(vs_edge),
    .cnt(line_no), .err(line_err)
  );

  vfield_window #(
    .CNT_W(CNT_W), .NTSC_FIRST(NTSC_FIRST), .NTSC_LAST(NTSC_LAST),
    .PAL_FIRST(PAL_FIRST), .PAL_LAST(PAL_LAST), .TSV(TSV),
    .SKIP_PERIOD(SKIP_PERIOD), .ODD_SKIP_A(ODD_SKIP_A), .ODD_SKIP_B(ODD_SKIP_B),
    .EVEN_SKIP_A(EVEN_SKIP_A), .EVEN_SKIP_B(EVEN_SKIP_B)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .cnt(line_no), .err(line_err), .cfg(cfg),
    .valid(line_valid), .skip(line_skip), .pulse(start_pulse)
  );

  assign start_a_oe  = ~cfg.up;
  assign start_b_oe  = cfg.up;
  assign start_a_out = start_pulse & ~cfg.up;
  assign start_b_out = start_pulse & cfg.up;
  assign field_even  = cfg.even;

  AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({start_a_oe, start_b_oe}) == 1); // R3
  AST_PULSE_ON_LINE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> $past(line_stb || vs_edge)); // R2

endmodule

// File: tb/vfield_seq_test.sv
module vfield_seq_test;

  localparam int LC   = 16;
  localparam int MAXL = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, vsync = 1'b0, pal_sel = 1'b0, dir_up = 1'b0;
  logic start_a_out, start_a_oe, start_b_out, start_b_oe;
  logic line_valid, line_skip, field_even, line_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vfield_seq #(.LINE_CLKS(LC), .MAX_LINES(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync(vsync),
    .pal_sel(pal_sel), .dir_up(dir_up),
    .start_a_out(start_a_out), .start_a_oe(start_a_oe),
    .start_b_out(start_b_out), .start_b_oe(start_b_oe),
    .line_valid(line_valid), .line_skip(line_skip),
    .field_even(field_even), .line_err(line_err)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Expected outputs for a line number n, computed from the requirements.
  task automatic check_line(input int n, input bit pal, input bit up,
                            input bit even, input bit flip);
    int first, last, row, ph;
    bit err, inwin, skip, valid, pulse;
    first = pal ? 28 : 22;
    last  = pal ? 299 : 256;
    err   = (n >= MAXL);
    inwin = !err && n >= first && n <= last;
    row   = n - first;
    ph    = row - (row / 14) * 14;
    skip  = inwin && pal && (even ? (ph == 3 || ph == 10) : (ph == 6 || ph == 12));
    valid = inwin && !skip;
    pulse = !err && (n + 3 == first);
    check(flip ? "R7 pins" : "R2 R3 pins",
          {start_a_out, start_a_oe, start_b_out, start_b_oe},
          {pulse & !up, !up, pulse & up, up});
    check(flip ? "R7 window" : (pal ? "R5 window" : "R4 window"),
          {line_valid, line_skip}, {valid, skip});
    check(flip ? "R7 parity" : "R6 parity", field_even, even);
    check("R8 err", line_err, err);
  endtask

  task automatic run_field(input bit pal, input bit up, input bit mid,
                           input int nlines, input bit flip);
    int vs_cyc;
    int n;
    vs_cyc = mid ? 9 : 1;
    for (int k = 0; k < nlines; k++) begin
      for (int c = 0; c < LC; c++) begin
        @(negedge clk);
        line_stb = (c == 0);
        if (k == 0) begin
          if (c == vs_cyc) begin
            vsync = 1'b1;
          end
          if (c == vs_cyc + 2) vsync = 1'b0;
          if (c == 0) begin
            pal_sel = pal;
            dir_up  = up;
          end
        end
        if (flip && k == 5 && c == 2) begin
          pal_sel = !pal;
          dir_up  = !up;
        end
        if (c == 12) begin
          n = (1 + k > MAXL) ? MAXL : 1 + k;
          check_line(n, pal, up, mid, flip && k > 5);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset",
          {start_a_out, start_a_oe, start_b_out, start_b_oe,
           line_valid, line_skip, field_even, line_err},
          8'b0100_0000);
    rst_n = 1'b1;
    // Sweep standard, direction and parity over whole fields.
    for (int cfgv = 0; cfgv < 8; cfgv++) begin
      run_field(cfgv[2], cfgv[1], cfgv[0], cfgv[2] ? 315 : 265, 1'b0);
    end
    // R7: mid-field flips of pal_sel and dir_up are ignored.
    run_field(1'b0, 1'b0, 1'b0, 265, 1'b1);
    run_field(1'b1, 1'b1, 1'b1, 315, 1'b1);
    // R8: missing sync saturates, then a normal field recovers.
    run_field(1'b0, 1'b1, 1'b0, 330, 1'b0);
    run_field(1'b1, 1'b0, 1'b1, 40, 1'b0);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 190000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule